// File: doc/BRIEF.md
# Multi-Level Prioritized Interrupt Controller

The controller gathers up to 46 interrupt request lines, numbered by vector. Each line gets a 2-bit priority field in a small register file. A field of 00 disables the line. Other values place the line on one of four priority levels. Each level has its own lowest-vector-first encoder. The controller then takes the highest populated level and compares it with the nesting state of the core. If that level is accepted, it presents a request, a vector number, a level and a handler address. Normal handlers sit in a table: base register shifted left by eight bits, plus twice the vector number. Two fast slots each name one vector. A matching source goes to the top of level 2 and jumps straight to an address held in that slot's own registers.

Some lines latch on a rising edge and stay pending until the core acknowledges that vector. The other lines follow their input level. Software reads the pending state of vectors 2 to 45 as a bitmap. A global disable bit blocks all requests. While the core is in a low-power state, any enabled pending request raises a wake output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every priority field, the vector base, every fast-slot register and the disable bit read 0, and no request or wake is raised.
- R2: For ordinary lines, field values 01, 10 and 11 put the line on levels 0, 1 and 2. For the upper-class lines (default vectors 2 and 3), the same values put it on levels 1, 2 and 3.
- R3: The request carries the highest level that has an enabled pending source. Within that level the lowest vector number wins.
- R4: With `core_busy_i` low, any level is accepted. When busy at level 0 only levels 1 to 3 are accepted, at level 1 only 2 and 3, and at level 2 or 3 only level 3. A rejected winner gives no request.
- R5: An enabled pending source whose vector equals a fast slot's match register is placed above all other level-2 sources and reported as level 2. Slot 0 beats slot 1, and level 3 still beats both.
- R6: A fast winner raises `fast_o`. Its address is {slot high register[7:0], slot low register[15:0]}.
- R7: A normal winner's address is {base[15:0], 8'h00} + 2 × vector.
- R8: Pending words at addresses 13, 14 and 15 hold vectors 2–17, 18–33 and 34–45 from bit 0 upward. A bit shows pending state whatever the line's priority field holds.
- R9: Edge lines (default vectors 0–15) latch on a rising input. They stay pending while the input remains high, and clear when `ack_i` arrives with their vector. Level lines follow their input.
- R10: Bit 0 of the control word (address 16) set to 1 blocks all requests and wake.
- R11: `wake_o` is high only while `lowpwr_i` is high and at least one enabled source is pending.
- R12: Register map: words 0–5 hold priority fields, with vector v at word v/8, bits 2(v%8)+1:2(v%8). Word 6 is the base. Fast slot 0 uses words 7 (match), 8 (low) and 9 (high); slot 1 uses words 10, 11 and 12. Written values read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| irq_i | input | 46 | Request lines, index = vector number |
| ack_i | input | 1 | Core acknowledge pulse |
| ack_vec_i | input | 6 | Vector being acknowledged |
| core_busy_i | input | 1 | Core is servicing an interrupt |
| core_lvl_i | input | 2 | Level of the interrupt being serviced |
| lowpwr_i | input | 1 | Core is in wait or stop |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 6 | Winning vector number |
| lvl_o | output | 2 | Winning level |
| fast_o | output | 1 | Winner is a fast slot |
| vaddr_o | output | 24 | Handler address |
| wake_o | output | 1 | Wake request to system integration |

## Verification
Some properties are checked on every cycle. The disable bit always blocks the request. A request never carries a level that the nesting state refuses. No populated level above the reported one is ever skipped. Fast winners always report level 2, and wake never rises outside low-power mode. Each encoder always returns a set input with nothing lower set, and an acknowledged edge line always clears. Other behaviour shows only in the bench's scenarios: the field decoding per line class, the two address formulas, slot 0 beating slot 1, the pending bitmap layout, and register readback.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic       on;
    logic [1:0] lvl;
  } lvl_t;

  // Decode a 2-bit priority field; upper-class lines sit one level higher.
  function automatic lvl_t decode_field(input logic [1:0] f, input logic upper);
    lvl_t r;
    r.on  = (f != 2'b00);
    r.lvl = upper ? f : f - 2'd1;
    return r;
  endfunction

  // Nesting acceptance of a candidate level against the core's state.
  function automatic logic nest_ok(input logic [1:0] l, input logic busy, input logic [1:0] cur);
    return !busy || (l == 2'd3) || (l > cur);
  endfunction
endpackage

// File: rtl/irq_lowenc.sv
module irq_lowenc #(
  parameter int N     = 46,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IDX_W'(i);
  end
  assign hit_o = |req_i;

  always_comb begin
    if (hit_o) begin
      // R3
      lowest_set_chk: assert (req_i[idx_o] && ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int                NUM_SRC   = 46,
  parameter int                VEC_W     = 6,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = NUM_SRC'(16'hFFFF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               ack_i,
  input  logic [VEC_W-1:0]   ack_vec_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q, latch_q;
      wire  rise = irq_i[i] && !prev_q;
      wire  clr  = ack_i && (ack_vec_i == VEC_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q  <= 1'b0;
          latch_q <= 1'b0;
        end else begin
          prev_q  <= irq_i[i];
          latch_q <= (latch_q && !clr) || rise;
        end
      end
      assign pend_o[i] = latch_q;
      // R9
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !latch_q);
    end else begin : g_lvl
      assign pend_o[i] = irq_i[i];
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile #(
  parameter int NUM_SRC = 46,
  parameter int VEC_W   = 6,
  parameter int DW      = 16,
  parameter int HI_W    = 8,
  parameter int ADDR_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  input  logic [NUM_SRC-1:0]            pend_i,
  output logic [NUM_SRC-1:0][1:0]       prio_o,
  output logic [DW-1:0]                 base_o,
  output logic [1:0][VEC_W-1:0]         fmatch_o,
  output logic [1:0][DW+HI_W-1:0]       faddr_o,
  output logic                          dis_o
);
  localparam int PRIO_WORDS = (NUM_SRC + 7) / 8;
  localparam int A_BASE     = PRIO_WORDS;
  localparam int A_FAST     = A_BASE + 1;
  localparam int A_PEND     = A_FAST + 6;
  localparam int PEND_WORDS = (NUM_SRC - 2 + DW - 1) / DW;
  localparam int A_CTRL     = A_PEND + PEND_WORDS;

  logic [1:0][DW-1:0]   flo_q;
  logic [1:0][HI_W-1:0] fhi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_o   <= '0;
      base_o   <= '0;
      fmatch_o <= '0;
      flo_q    <= '0;
      fhi_q    <= '0;
      dis_o    <= 1'b0;
    end else if (wr_i) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (addr_i == ADDR_W'(i / 8)) prio_o[i] <= wdata_i[2*(i%8) +: 2];
      if (addr_i == ADDR_W'(A_BASE)) base_o <= wdata_i;
      for (int s = 0; s < 2; s++) begin
        if (addr_i == ADDR_W'(A_FAST + 3*s))     fmatch_o[s] <= wdata_i[VEC_W-1:0];
        if (addr_i == ADDR_W'(A_FAST + 3*s + 1)) flo_q[s]    <= wdata_i;
        if (addr_i == ADDR_W'(A_FAST + 3*s + 2)) fhi_q[s]    <= wdata_i[HI_W-1:0];
      end
      if (addr_i == ADDR_W'(A_CTRL)) dis_o <= wdata_i[0];
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_fa
    assign faddr_o[s] = {fhi_q[s], flo_q[s]};
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < PRIO_WORDS; w++)
      if (addr_i == ADDR_W'(w))
        for (int j = 0; j < 8; j++)
          if (8*w + j < NUM_SRC) rdata_o[2*j +: 2] = prio_o[8*w + j];
    if (addr_i == ADDR_W'(A_BASE)) rdata_o = base_o;
    for (int s = 0; s < 2; s++) begin
      if (addr_i == ADDR_W'(A_FAST + 3*s))     rdata_o = DW'(fmatch_o[s]);
      if (addr_i == ADDR_W'(A_FAST + 3*s + 1)) rdata_o = flo_q[s];
      if (addr_i == ADDR_W'(A_FAST + 3*s + 2)) rdata_o = DW'(fhi_q[s]);
    end
    for (int k = 0; k < PEND_WORDS; k++)
      if (addr_i == ADDR_W'(A_PEND + k))
        for (int b = 0; b < DW; b++)
          if (2 + DW*k + b < NUM_SRC) rdata_o[b] = pend_i[2 + DW*k + b];
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o = DW'(dis_o);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int                 NUM_SRC   = 46,
  parameter int                 VEC_W     = 6,
  parameter int                 DW        = 16,
  parameter int                 HI_W      = 8,
  parameter int                 ADDR_W    = 5,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = NUM_SRC'(16'hFFFF),
  parameter logic [NUM_SRC-1:0] HIGH_MASK = NUM_SRC'(4'hC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DW-1:0]          bus_wdata_i,
  output logic [DW-1:0]          bus_rdata_o,
  input  logic [NUM_SRC-1:0]     irq_i,
  input  logic                   ack_i,
  input  logic [VEC_W-1:0]       ack_vec_i,
  input  logic                   core_busy_i,
  input  logic [1:0]             core_lvl_i,
  input  logic                   lowpwr_i,
  output logic                   req_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic [1:0]             lvl_o,
  output logic                   fast_o,
  output logic [DW+HI_W-1:0]     vaddr_o,
  output logic                   wake_o
);
  import irq_pkg::*;
  localparam int LVLS    = 4;
  localparam int VADDR_W = DW + HI_W;

  function automatic logic [VADDR_W-1:0] table_addr(input logic [DW-1:0] base, input logic [VEC_W-1:0] v);
    return {base, HI_W'(0)} + VADDR_W'({v, 1'b0});
  endfunction

  logic [NUM_SRC-1:0]        pend, active, is_fast;
  logic [NUM_SRC-1:0][1:0]   prio;
  logic [DW-1:0]             base;
  logic [1:0][VEC_W-1:0]     fmatch;
  logic [1:0][VADDR_W-1:0]   faddr;
  logic                      dis;
  logic [LVLS-1:0][NUM_SRC-1:0] lvl_req;
  logic [LVLS-1:0]           enc_hit, lvl_any;
  logic [LVLS-1:0][VEC_W-1:0] enc_idx;
  logic                      f0_hit, f1_hit, any_win;
  logic [1:0]                win_lvl;

  irq_regfile #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DW(DW), .HI_W(HI_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .pend_i(pend), .prio_o(prio), .base_o(base), .fmatch_o(fmatch),
    .faddr_o(faddr), .dis_o(dis));

  irq_pending #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ack_i(ack_i), .ack_vec_i(ack_vec_i), .pend_o(pend));

  always_comb begin
    lvl_t d;
    lvl_req = '0;
    f0_hit  = 1'b0;
    f1_hit  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      d          = decode_field(prio[i], HIGH_MASK[i]);
      active[i]  = pend[i] && d.on;
      is_fast[i] = (fmatch[0] == VEC_W'(i)) || (fmatch[1] == VEC_W'(i));
      if (active[i] && fmatch[0] == VEC_W'(i)) f0_hit = 1'b1;
      if (active[i] && fmatch[1] == VEC_W'(i)) f1_hit = 1'b1;
      for (int l = 0; l < LVLS; l++)
        lvl_req[l][i] = active[i] && !is_fast[i] && (d.lvl == 2'(l));
    end
  end

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    irq_lowenc #(.N(NUM_SRC), .IDX_W(VEC_W)) u_enc (
      .req_i(lvl_req[l]), .hit_o(enc_hit[l]), .idx_o(enc_idx[l]));
    if (l == 2) begin : g_fast
      assign lvl_any[l] = enc_hit[l] || f0_hit || f1_hit;
    end else begin : g_norm
      assign lvl_any[l] = enc_hit[l];
    end
  end

  always_comb begin
    win_lvl = 2'd0;
    for (int l = 0; l < LVLS; l++)
      if (lvl_any[l]) win_lvl = 2'(l);
    any_win = |lvl_any;
    fast_o  = 1'b0;
    vec_o   = enc_idx[win_lvl];
    vaddr_o = table_addr(base, enc_idx[win_lvl]);
    if (win_lvl == 2'd2 && (f0_hit || f1_hit)) begin
      fast_o  = 1'b1;
      vec_o   = f0_hit ? fmatch[0] : fmatch[1];
      vaddr_o = f0_hit ? faddr[0] : faddr[1];
    end
  end

  assign lvl_o  = win_lvl;
  assign req_o  = any_win && !dis && nest_ok(win_lvl, core_busy_i, core_lvl_i);
  assign wake_o = lowpwr_i && any_win && !dis;

  // R10
  dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) dis |-> !req_o);
  // R4
  nest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && core_busy_i && core_lvl_i != 2'd3) |-> (lvl_o > core_lvl_i));
  // R3
  top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((lvl_any >> lvl_o) == 4'd1));
  // R5
  fast_is_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && fast_o) |-> (lvl_o == 2'd2));
  // R11
  wake_lowpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (lowpwr_i && !dis));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [45:0] irq = '0;
  logic ack = 1'b0;
  logic [5:0] ack_vec = '0;
  logic busy = 1'b0;
  logic [1:0] clvl = '0;
  logic lowpwr = 1'b0;
  logic req, fast, wake;
  logic [5:0] vec;
  logic [1:0] lvl;
  logic [23:0] vaddr;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_i(irq), .ack_i(ack), .ack_vec_i(ack_vec), .core_busy_i(busy),
    .core_lvl_i(clvl), .lowpwr_i(lowpwr), .req_o(req), .vec_o(vec), .lvl_o(lvl), .fast_o(fast),
    .vaddr_o(vaddr), .wake_o(wake));

  typedef struct {
    bit          is_rd;
    logic [15:0] rd;
    logic        req;
    logic [5:0]  vec;
    logic [1:0]  lvl;
    logic        fast;
    logic [23:0] addr;
    logic        wake;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [15:0] pw [6];

  function automatic logic [23:0] na(input int v);
    return 24'h001200 + 24'(2 * v);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input int a, input logic [15:0] d);
    tick();
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic set_prio(input int v, input logic [1:0] f);
    pw[v/8][2*(v%8) +: 2] = f;
    bus_write(v / 8, pw[v/8]);
  endtask

  task automatic exp_out(input string tag, input logic r, input int v, input int l,
                         input logic f, input logic [23:0] a, input logic w);
    exp_t e;
    e.is_rd = 1'b0; e.rd = '0; e.req = r; e.vec = 6'(v); e.lvl = 2'(l);
    e.fast = f; e.addr = a; e.wake = w; e.tag = tag;
    exp_q.push_back(e);
    tick();
  endtask

  task automatic exp_rd(input string tag, input int a, input logic [15:0] d);
    exp_t e;
    bus_addr = 5'(a);
    e.is_rd = 1'b1; e.rd = d; e.req = 1'b0; e.vec = '0; e.lvl = '0;
    e.fast = 1'b0; e.addr = '0; e.wake = 1'b0; e.tag = tag;
    exp_q.push_back(e);
    tick();
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #2;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_chk++;
        if (e.is_rd) begin
          if (bus_rdata !== e.rd) begin
            n_err++;
            $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.rd);
          end
        end else if (req !== e.req || wake !== e.wake ||
                     (e.req && (vec !== e.vec || lvl !== e.lvl || fast !== e.fast || vaddr !== e.addr))) begin
          n_err++;
          $display("FAIL %s: req=%b vec=%0d lvl=%0d fast=%b addr=%h wake=%b expected req=%b vec=%0d lvl=%0d fast=%b addr=%h wake=%b",
                   e.tag, req, vec, lvl, fast, vaddr, wake, e.req, e.vec, e.lvl, e.fast, e.addr, e.wake);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) pw[k] = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    exp_out("R1 idle", 0, 0, 0, 0, 0, 0);
    exp_rd("R1 prio word", 0, 16'h0000);
    exp_rd("R1 ctrl word", 16, 16'h0000);
    exp_rd("R1 fast match", 7, 16'h0000);

    // R12 register setup and readback
    bus_write(6, 16'h0012);
    bus_write(8, 16'hBEEF); bus_write(9, 16'h003A);
    bus_write(11, 16'h1234); bus_write(12, 16'h0005);
    exp_rd("R12 base", 6, 16'h0012);
    exp_rd("R12 fast0 high", 9, 16'h003A);
    exp_rd("R12 fast1 low", 11, 16'h1234);

    // R2 ordinary decoding, R7 table address
    irq[20] = 1'b1;
    set_prio(20, 2'b01);
    exp_out("R2 f01 level0 R7", 1, 20, 0, 0, na(20), 0);
    set_prio(20, 2'b11);
    exp_out("R2 f11 level2", 1, 20, 2, 0, na(20), 0);
    set_prio(20, 2'b10);
    exp_out("R2 f10 level1", 1, 20, 1, 0, na(20), 0);
    exp_rd("R12 prio word2", 2, 16'h0200);

    // R3 lowest vector in a level, highest level overall
    irq[17] = 1'b1;
    set_prio(17, 2'b10);
    exp_out("R3 lowest in level", 1, 17, 1, 0, na(17), 0);
    irq[30] = 1'b1;
    set_prio(30, 2'b11);
    exp_out("R3 higher level wins", 1, 30, 2, 0, na(30), 0);

    // R4 nesting
    busy = 1'b1; clvl = 2'd2;
    exp_out("R4 busy2 rejects lvl2", 0, 30, 2, 0, na(30), 0);
    clvl = 2'd1;
    exp_out("R4 busy1 accepts lvl2", 1, 30, 2, 0, na(30), 0);
    clvl = 2'd0; busy = 1'b0;

    // R2 upper-class line 3 (edge line, R9 latch)
    set_prio(3, 2'b10);
    irq[3] = 1'b1;
    tick();
    exp_out("R2 upper f10 level2", 1, 3, 2, 0, na(3), 0);
    set_prio(3, 2'b11);
    exp_out("R2 upper f11 level3", 1, 3, 3, 0, na(3), 0);
    busy = 1'b1; clvl = 2'd3;
    exp_out("R4 busy3 accepts lvl3", 1, 3, 3, 0, na(3), 0);
    busy = 1'b0; clvl = 2'd0;

    // R8 pending bitmap
    exp_rd("R8 pend word13", 13, 16'h8002);
    exp_rd("R8 pend word14", 14, 16'h1004);

    // R9 acknowledge clears the edge line while input stays high
    ack = 1'b1; ack_vec = 6'd3;
    tick();
    ack = 1'b0;
    exp_out("R9 ack cleared", 1, 30, 2, 0, na(30), 0);
    exp_rd("R9 pend after ack", 13, 16'h8000);

    // R5 / R6 fast slots
    bus_write(7, 16'd25);
    irq[25] = 1'b1;
    set_prio(25, 2'b11);
    exp_out("R5 fast0 over lvl2 R6", 1, 25, 2, 1, 24'h3ABEEF, 0);
    bus_write(10, 16'd17);
    set_prio(17, 2'b11);
    exp_out("R5 slot0 beats slot1", 1, 25, 2, 1, 24'h3ABEEF, 0);
    irq[25] = 1'b0;
    exp_out("R6 fast1 address", 1, 17, 2, 1, 24'h051234, 0);
    irq[3] = 1'b0;
    tick();
    irq[3] = 1'b1;
    tick();
    exp_out("R5 level3 beats fast", 1, 3, 3, 0, na(3), 0);

    // R10 global disable, R11 wake
    bus_write(16, 16'h0001);
    exp_out("R10 disabled", 0, 3, 3, 0, na(3), 0);
    exp_rd("R10 ctrl readback", 16, 16'h0001);
    lowpwr = 1'b1;
    exp_out("R11 no wake when disabled", 0, 3, 3, 0, na(3), 0);
    bus_write(16, 16'h0000);
    exp_out("R11 wake", 1, 3, 3, 0, na(3), 1);
    lowpwr = 1'b0;
    exp_out("R11 wake drops", 1, 3, 3, 0, na(3), 0);

    // clear everything
    irq = '0;
    ack = 1'b1; ack_vec = 6'd3;
    tick();
    ack = 1'b0;
    lowpwr = 1'b1;
    exp_out("R11 nothing pending", 0, 0, 0, 0, 0, 0);
    irq[40] = 1'b1;
    exp_out("R11 disabled line no wake", 0, 0, 0, 0, 0, 0);
    exp_rd("R8 raw pending word15", 15, 16'h0040);
    irq[40] = 1'b0;

    // R9 edge line 5 at level 0
    set_prio(5, 2'b01);
    irq[5] = 1'b1;
    tick();
    exp_out("R9 edge latched", 1, 5, 0, 0, na(5), 1);
    tick(); tick();
    exp_out("R9 held pending", 1, 5, 0, 0, na(5), 1);
    exp_rd("R8 pend word13 vec5", 13, 16'h0008);
    ack = 1'b1; ack_vec = 6'd5;
    tick();
    ack = 1'b0;
    exp_out("R9 ack clears vec5", 0, 0, 0, 0, 0, 0);
    exp_rd("R9 pend cleared", 13, 16'h0000);

    tick(); tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule